// File: doc/BRIEF.md
# Cascaded Converter Serial Readout Chain

This block models the digital output path of a chain of multichannel sampling converters that share one serial data line. Each device in the chain holds one 24-bit word per channel. A single read, framed by one low period of the active-low select, streams every word of every device: the first device sends its channels in ascending order, raises its hand-off output when its last bit has gone, and the next device then drives the shared line with its own channels. With the default two devices of four channels, one read is 192 bits.

Each device also has an active-low ready output. The first device's ready reflects only its own unread conversion. Every later device combines its own state with the ready output of the device before it, so the last output of the chain falls only when all devices hold unread data. The host then reads the whole chain once. Samples are captured into the shift paths when select falls, so conversions that finish during a read cannot corrupt it.

The serial clock and select are sampled on the system clock. Both must be held for at least two system clock periods per level.

Top module: `casc_spi_readout`

## Requirements
- R1: Out of reset, `dout_oe_o` is 0, `casc_no` is all ones and `rdy_no` is all ones.
- R2: Sample words are captured from `smp_data_i` in the cycle `cs_ni` falls. Changes to `smp_data_i` during the read do not alter the bits sent. Device k, channel c sits at `smp_data_i[(k*N_CH+c)*W +: W]`.
- R3: Data is sent MSB first. The first bit is on `dout_o` before the first rising edge of `sclk_i` after select falls. The line changes only after a falling edge of `sclk_i`, never across a rising edge.
- R4: One read streams device 0 channels 0,1,2,3 and then device 1 channels 0,1,2,3, N_DEV*N_CH*W bits in total.
- R5: `casc_no[k]` stays high until the falling `sclk_i` edge that follows device k's last bit. It goes low at that edge, and from then on device k+1 drives `dout_o` starting with its first MSB.
- R6: After the full stream, with select still low, `dout_oe_o` is 0 and `casc_no` is all zeros.
- R7: When `cs_ni` rises, `dout_oe_o` falls at once and `casc_no` returns to all ones one cycle later. A read aborted part way restarts from device 0, channel 0, MSB.
- R8: `rdy_no[0]` goes low the cycle after `smp_valid_i[0]` pulses, provided `rdy_ni` is low. It returns high when select falls.
- R9: `rdy_no[k]` for k>0 is low only when device k has an unread sample and `rdy_no[k-1]` is low.
- R10: With `casc_ni` high, no device drives `dout_o`. With `rdy_ni` high, every `rdy_no` stays high.
- R11: At most one device drives the line at any time, and `dout_oe_o` is high throughout the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Read select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| smp_data_i | input | N_DEV*N_CH*W | Current conversion words of all devices |
| smp_valid_i | input | N_DEV | One-cycle pulse per device when a new conversion is ready |
| casc_ni | input | 1 | Hand-off input of the first device, tie low |
| rdy_ni | input | 1 | Ready input of the first device, tie low |
| dout_o | output | 1 | Shared serial data |
| dout_oe_o | output | 1 | Output enable of the shared line |
| casc_no | output | N_DEV | Per-device hand-off output, low once the device is done |
| rdy_no | output | N_DEV | Chained ready outputs, active low |

## Verification
On every cycle the assertions check four things. Only one device drives at a time. A device never reports done before the device ahead of it. The ready chain falls in order. The data line holds still between falling serial clock edges. Select high also releases the line and clears the hand-offs. Only the directed scenarios can show the content of the stream: the order of words and bits, immunity to data that changes mid-read, the exact hand-off bit position, and a restart after an aborted read. These rest on values the bench computes itself from the data it applies.

// File: rtl/casc_spi_pkg.sv
package casc_spi_pkg;
  localparam int unsigned DEF_N_DEV = 2;
  localparam int unsigned DEF_N_CH  = 4;
  localparam int unsigned DEF_W     = 24;

  function automatic int unsigned cnt_width(input int unsigned bits);
    return $clog2(bits + 1);
  endfunction
endpackage

// File: rtl/casc_spi_edge.sv
module casc_spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic sclk_fall_o,
  output logic cs_fall_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign cs_fall_o   = cs_q & ~cs_ni;
endmodule

// File: rtl/casc_spi_dev.sv
module casc_spi_dev #(
  parameter int unsigned N_CH = casc_spi_pkg::DEF_N_CH,
  parameter int unsigned W    = casc_spi_pkg::DEF_W,
  localparam int unsigned DEV_BITS = N_CH * W,
  localparam int unsigned CNT_W    = casc_spi_pkg::cnt_width(DEV_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                cs_fall_i,
  input  logic                sclk_fall_i,
  input  logic [DEV_BITS-1:0] smp_i,
  input  logic                casc_ni,
  output logic                casc_no,
  output logic                drv_o,
  output logic                bit_o
);
  logic [DEV_BITS-1:0] sr_q, sr_load;
  logic [CNT_W-1:0]    cnt_q;
  logic                done_q;
  logic                active;

  // channel 0 goes to the top of the shift path
  for (genvar c = 0; c < N_CH; c++) begin : g_order
    assign sr_load[(N_CH-1-c)*W +: W] = smp_i[c*W +: W];
  end

  assign active = ~cs_ni & ~casc_ni & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cs_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cs_fall_i) begin
      sr_q   <= sr_load;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (sclk_fall_i && active) begin
      sr_q  <= {sr_q[DEV_BITS-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DEV_BITS - 1)) done_q <= 1'b1;
    end
  end

  assign casc_no = ~done_q;
  assign drv_o   = active;
  assign bit_o   = sr_q[DEV_BITS-1];
endmodule

// File: rtl/casc_spi_rdy.sv
module casc_spi_rdy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic valid_i,
  input  logic rdy_ni,
  output logic rdy_no
);
  logic own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        own_q <= 1'b0;
    else if (valid_i)   own_q <= 1'b1;   // new conversion wins over read start
    else if (cs_fall_i) own_q <= 1'b0;
  end

  assign rdy_no = ~(own_q & ~rdy_ni);
endmodule

// File: rtl/casc_spi_readout.sv
module casc_spi_readout #(
  parameter int unsigned N_DEV = casc_spi_pkg::DEF_N_DEV,
  parameter int unsigned N_CH  = casc_spi_pkg::DEF_N_CH,
  parameter int unsigned W     = casc_spi_pkg::DEF_W,
  localparam int unsigned DEV_BITS = N_CH * W,
  localparam int unsigned ALL_BITS = N_DEV * DEV_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic [ALL_BITS-1:0] smp_data_i,
  input  logic [N_DEV-1:0]    smp_valid_i,
  input  logic                casc_ni,
  input  logic                rdy_ni,
  output logic                dout_o,
  output logic                dout_oe_o,
  output logic [N_DEV-1:0]    casc_no,
  output logic [N_DEV-1:0]    rdy_no
);
  logic             sclk_fall, cs_fall;
  logic [N_DEV-1:0] drv, dbit, casc_in, rdy_in;

  casc_spi_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .sclk_fall_o(sclk_fall),
    .cs_fall_o  (cs_fall)
  );

  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    if (k == 0) begin : g_head
      assign casc_in[k] = casc_ni;
      assign rdy_in[k]  = rdy_ni;
    end else begin : g_link
      assign casc_in[k] = casc_no[k-1];
      assign rdy_in[k]  = rdy_no[k-1];
    end

    casc_spi_dev #(.N_CH(N_CH), .W(W)) u_dev (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cs_ni      (cs_ni),
      .cs_fall_i  (cs_fall),
      .sclk_fall_i(sclk_fall),
      .smp_i      (smp_data_i[k*DEV_BITS +: DEV_BITS]),
      .casc_ni    (casc_in[k]),
      .casc_no    (casc_no[k]),
      .drv_o      (drv[k]),
      .bit_o      (dbit[k])
    );

    casc_spi_rdy u_rdy (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cs_fall_i(cs_fall),
      .valid_i  (smp_valid_i[k]),
      .rdy_ni   (rdy_in[k]),
      .rdy_no   (rdy_no[k])
    );
  end

  assign dout_oe_o = |drv;
  assign dout_o    = |(drv & dbit);
endmodule

// File: rtl/casc_spi_readout_chk.sv
module casc_spi_readout_chk #(
  parameter int unsigned N_DEV = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sclk_fall_i,
  input logic [N_DEV-1:0] drv_i,
  input logic             dout_o,
  input logic             dout_oe_i,
  input logic [N_DEV-1:0] casc_no,
  input logic [N_DEV-1:0] rdy_no
);
  logic cs_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_low_q <= 1'b0;
    else         cs_low_q <= ~cs_ni;
  end

  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_i)); // R11

  AST_RELEASE_ON_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !dout_oe_i); // R7

  AST_CASC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (casc_no == '1)); // R7

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && cs_low_q && !sclk_fall_i) |=> ($stable(dout_o) || cs_ni)); // R3

  for (genvar k = 1; k < N_DEV; k++) begin : g_pair
    AST_CASC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !casc_no[k] |-> !casc_no[k-1]); // R5
    AST_RDY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdy_no[k] |-> !rdy_no[k-1]); // R9
  end
endmodule

bind casc_spi_readout casc_spi_readout_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sclk_fall_i(sclk_fall),
  .drv_i      (drv),
  .dout_o     (dout_o),
  .dout_oe_i  (dout_oe_o),
  .casc_no    (casc_no),
  .rdy_no     (rdy_no)
);

// File: tb/casc_spi_readout_test.sv
module casc_spi_readout_test;
  localparam int NB = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic [NB-1:0] smp_data = '0;
  logic [1:0]    smp_valid = '0;
  logic          casc_n = 1'b0;
  logic          rdy_n = 1'b0;
  logic          dout, dout_oe;
  logic [1:0]    casc_no, rdy_no;

  int checks = 0;
  int failures = 0;
  logic [NB-1:0] got;
  int unstable, oe_low;

  always #2.5 clk = ~clk;

  casc_spi_readout uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .smp_data_i(smp_data), .smp_valid_i(smp_valid),
    .casc_ni(casc_n), .rdy_ni(rdy_n),
    .dout_o(dout), .dout_oe_o(dout_oe), .casc_no(casc_no), .rdy_no(rdy_no)
  );

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] word(input int seed, input int idx);
    return 24'(seed * 32'h9E3779 + idx * 32'h10101 + 32'h800001);
  endfunction

  function automatic logic [NB-1:0] pack(input int seed);
    logic [NB-1:0] v;
    for (int i = 0; i < 8; i++) v[i*24 +: 24] = word(seed, i);
    return v;
  endfunction

  function automatic logic [NB-1:0] stream(input int seed);
    logic [NB-1:0] v;
    for (int i = 0; i < 8; i++) v[NB-1-24*i -: 24] = word(seed, i);
    return v;
  endfunction

  task automatic read_bits(input int n);
    for (int i = 0; i < n; i++) begin
      logic b;
      repeat (2) @(negedge clk);
      b = dout;
      if (!dout_oe) oe_low++;
      got = {got[NB-2:0], b};
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      if (dout !== b) unstable++;
      sclk = 1'b0;
    end
  endtask

  task automatic pulse_valid(input logic [1:0] v);
    @(negedge clk); smp_valid = v;
    @(negedge clk); smp_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oe", NB'(dout_oe), NB'(0));
    chk("R1 casc", NB'(casc_no), NB'(2'b11));
    chk("R1 rdy", NB'(rdy_no), NB'(2'b11));
  endtask

  task automatic t_stream(input int seed);
    logic [NB-1:0] exp = stream(seed);
    smp_data = pack(seed);
    pulse_valid(2'b11);
    chk("R8 R9 both ready", NB'(rdy_no), NB'(2'b00));
    got = '0; unstable = 0; oe_low = 0;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    smp_data = ~pack(seed);        // R2: must not reach the stream
    @(negedge clk);
    chk("R8 cleared at read", NB'(rdy_no), NB'(2'b11));
    read_bits(95);
    chk("R5 before hand-off", NB'(casc_no), NB'(2'b11));
    read_bits(1);
    repeat (2) @(negedge clk);
    chk("R5 hand-off", NB'(casc_no), NB'(2'b10));
    chk("R5 dev1 msb", NB'(dout), NB'(exp[95]));
    read_bits(96);
    repeat (2) @(negedge clk);
    chk("R4 R2 stream", got, exp);
    chk("R3 stable on rise", NB'(unstable), NB'(0));
    chk("R11 oe throughout", NB'(oe_low), NB'(0));
    chk("R6 oe after end", NB'(dout_oe), NB'(0));
    chk("R6 casc after end", NB'(casc_no), NB'(2'b00));
    cs_n = 1'b1;
    #1 chk("R7 oe release", NB'(dout_oe), NB'(0));
    repeat (2) @(negedge clk);
    chk("R7 casc clear", NB'(casc_no), NB'(2'b11));
  endtask

  task automatic t_abort(input int seed);
    logic [NB-1:0] exp = stream(seed);
    smp_data = pack(seed);
    @(negedge clk); cs_n = 1'b0;
    got = '0;
    read_bits(50);
    @(negedge clk); cs_n = 1'b1;
    #1 chk("R7 abort release", NB'(dout_oe), NB'(0));
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    got = '0; unstable = 0;
    read_bits(24);
    chk("R7 restart ch0", got[23:0], exp[NB-1 -: 24]);
    chk("R3 msb first", NB'(got[23]), NB'(exp[NB-1]));
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_ready_chain;
    pulse_valid(2'b10);
    chk("R9 dev1 alone", NB'(rdy_no), NB'(2'b11));
    pulse_valid(2'b01);
    chk("R9 both", NB'(rdy_no), NB'(2'b00));
    rdy_n = 1'b1;
    #1 chk("R10 rdy blocked", NB'(rdy_no), NB'(2'b11));
    rdy_n = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 read clears", NB'(rdy_no), NB'(2'b11));
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_casc_block;
    casc_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    oe_low = 0; got = '0;
    read_bits(10);
    chk("R10 no driver", NB'(oe_low), NB'(10));
    chk("R10 casc held", NB'(casc_no), NB'(2'b11));
    @(negedge clk); cs_n = 1'b1; casc_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_stream(1);
    t_stream(7);
    t_abort(3);
    t_ready_chain();
    t_casc_block();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule